// File: doc/BRIEF.md
# Byte Mailbox Between Two Processors

This block passes bytes between a local processor and a peer host. The local side sees a small I/O window. Address bits 7:5 pick one of eight port groups, and the lower address bits are don't-care. The block holds two data registers. The outbound register carries bytes from the local processor to the host, and the inbound register carries bytes from the host to the local processor. Each register has a pending flag that tells the receiving side a fresh byte is waiting.

The flags change only as side effects of port accesses. A write to a register raises its flag. The receiving side clears the flag when it reads the register. Both flags can be read together through one status port on the local side. The host side has a plain one-byte read and write port on the same two registers.

Every read returns its data through a register, one clock after the strobe. The block acts on the first cycle of a strobe, so a strobe that stays high for several cycles takes effect only once.

Top module: `mbox_xfer`

## Requirements
- R1: After a synchronous reset, both pending flags are 0 and both read-data outputs are 0x00.
- R2: The local port group is `cpu_addr[7:5]`. Bits 4:0 have no effect on any access.
- R3: A local write to group 0 loads the outbound register and sets `host_pend`. Local writes to groups 1 to 7 change neither register nor flag.
- R4: A local read of group 0 returns the outbound register and leaves both flags unchanged.
- R5: A local read of group 1 returns the inbound register and clears `cpu_pend`.
- R6: A local read of group 2 returns a status byte. Bit 7 is `cpu_pend`, bit 0 is `host_pend`, and bits 6:1 are 0.
- R7: Local reads of groups 3 to 7 return 0x00.
- R8: A host write loads the inbound register and sets `cpu_pend`.
- R9: A host read returns the outbound register and clears `host_pend`.
- R10: When a flag is set and cleared in the same cycle, it ends up set. The register still loads the new byte, and the read returns the old byte.
- R11: A strobe takes effect only in the first cycle it is high. Holding it high for more cycles does nothing more.
- R12: Read data appears on the output one clock after the read strobe's first cycle. It holds until the next read on the same side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Local I/O address; bits 7:5 select the group |
| cpu_wdata | input | 8 | Local write data |
| cpu_wr | input | 1 | Local write strobe |
| cpu_rd | input | 1 | Local read strobe |
| cpu_rdata | output | 8 | Registered local read data |
| host_wdata | input | 8 | Host write data (to inbound register) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (outbound register) |
| host_rdata | output | 8 | Registered host read data |
| host_pend | output | 1 | Outbound byte waiting for the host |
| cpu_pend | output | 1 | Inbound byte waiting for the local processor |

## Verification
The assertions check on every cycle that:
- each write sets its flag;
- each read clears its flag, unless a set arrives in the same cycle;
- the unused status bits stay at zero;
- flags and read data stay still while no strobe starts.

Some behaviour only the bench scenarios can show:
- the actual bytes returned;
- that the lower address bits are ignored;
- that writes to unused groups are dropped;
- that set beats clear in both directions;
- that a held strobe acts only once, even when the host refills the register during the hold.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int GRP_W   = 3;
  localparam int N_GRP   = 1 << GRP_W;
  localparam int G_OUT   = 0;  // outbound data
  localparam int G_IN    = 1;  // inbound data
  localparam int G_STAT  = 2;  // status
  localparam int N_STRB  = 4;
  localparam int S_CWR   = 0;
  localparam int S_CRD   = 1;
  localparam int S_HWR   = 2;
  localparam int S_HRD   = 3;
endpackage

// File: rtl/mbox_edge.sv
module mbox_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;  // set has priority over clear
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_p,
  input  logic              wr_p,
  output logic [N_GRP-1:0]  rd_grp,
  output logic [N_GRP-1:0]  wr_grp
);
  localparam int SPAN = 1 << (ADDR_W - GRP_W);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(g * SPAN);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'((g + 1) * SPAN);
    logic hit;
    assign hit       = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    assign rd_grp[g] = rd_p & hit;
    assign wr_grp[g] = wr_p & hit;
  end
endmodule

// File: rtl/mbox_xfer.sv
module mbox_xfer
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_pend,
  output logic              cpu_pend
);
  logic [N_STRB-1:0] strb_lvl, strb_p;
  logic [N_GRP-1:0]  rd_grp, wr_grp;
  logic [DATA_W-1:0] out_q, in_q, rd_val, stat;

  assign strb_lvl = {host_rd, host_wr, cpu_rd, cpu_wr};

  mbox_edge #(.N(N_STRB)) u_edge (
    .clk(clk), .rst(rst), .lvl(strb_lvl), .pulse(strb_p)
  );

  mbox_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(cpu_addr), .rd_p(strb_p[S_CRD]), .wr_p(strb_p[S_CWR]),
    .rd_grp(rd_grp), .wr_grp(wr_grp)
  );

  mbox_flag u_host_flag (
    .clk(clk), .rst(rst),
    .set(wr_grp[G_OUT]), .clr(strb_p[S_HRD]), .q(host_pend)
  );

  mbox_flag u_cpu_flag (
    .clk(clk), .rst(rst),
    .set(strb_p[S_HWR]), .clr(rd_grp[G_IN]), .q(cpu_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (wr_grp[G_OUT]) out_q <= cpu_wdata;
      if (strb_p[S_HWR]) in_q  <= host_wdata;
    end
  end

  always_comb begin
    stat           = '0;
    stat[DATA_W-1] = cpu_pend;
    stat[0]        = host_pend;
  end

  always_comb begin
    rd_val = '0;
    if (rd_grp[G_OUT])  rd_val = out_q;
    if (rd_grp[G_IN])   rd_val = in_q;
    if (rd_grp[G_STAT]) rd_val = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      if (strb_p[S_CRD]) cpu_rdata  <= rd_val;
      if (strb_p[S_HRD]) host_rdata <= out_q;
    end
  end
endmodule

// File: rtl/mbox_xfer_chk.sv
module mbox_xfer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_pend,
  input logic              cpu_pend
);
  logic [2:0] grp;
  assign grp = cpu_addr[ADDR_W-1 -: 3];

  AST_OUT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_wr) && grp == 3'd0 |=> host_pend);  // R3

  AST_HOST_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wr) |=> cpu_pend);  // R8

  AST_IN_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rd) && grp == 3'd1 && !host_wr |=> !cpu_pend);  // R5

  AST_HOST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rd) && !cpu_wr |=> !host_pend);  // R9

  AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rd) && grp == 3'd2 |=> cpu_rdata[DATA_W-2:1] == '0);  // R6

  AST_FLAGS_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr && !cpu_rd && !host_wr && !host_rd |=> $stable(host_pend) && $stable(cpu_pend));  // R11

  AST_CPU_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));  // R12

  AST_HOST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));  // R12
endmodule

bind mbox_xfer mbox_xfer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_rdata(cpu_rdata), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .host_pend(host_pend), .cpu_pend(cpu_pend)
);

// File: tb/sim_mbox_xfer.sv
`timescale 1ns/1ps
module sim_mbox_xfer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, host_wdata = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] cpu_rdata, host_rdata;
  logic       host_pend, cpu_pend;

  always #2 clk = ~clk;  // 250 MHz

  mbox_xfer u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_pend(host_pend), .cpu_pend(cpu_pend)
  );

  typedef struct {
    int         due;
    bit         host_side;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected read data on the cycle it is due
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t it;
      logic [7:0] act;
      it  = exp_q.pop_front();
      act = it.host_side ? host_rdata : cpu_rdata;
      n_vec++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s %s rdata actual=%02h expected=%02h",
                 it.req, it.host_side ? "host" : "cpu", act, it.val);
      end
    end
  end

  task automatic push(input bit hs, input logic [7:0] v, input string req);
    exp_t it;
    it.due = cyc + 1; it.host_side = hs; it.val = v; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle of strobes, all launched at a falling edge
  task automatic cyc_drive(input bit cw, input bit cr, input bit hw, input bit hr,
                           input logic [7:0] a, input logic [7:0] cd, input logic [7:0] hd);
    cpu_wr = cw; cpu_rd = cr; host_wr = hw; host_rd = hr;
    cpu_addr = a; cpu_wdata = cd; host_wdata = hd;
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; host_wr = 0; host_rd = 0;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    cyc_drive(1, 0, 0, 0, a, d, 8'h00);
  endtask

  task automatic cpu_read(input logic [7:0] a, input logic [7:0] e, input string req);
    push(0, e, req);
    cyc_drive(0, 1, 0, 0, a, 8'h00, 8'h00);
  endtask

  task automatic host_write(input logic [7:0] d);
    cyc_drive(0, 0, 1, 0, 8'h00, 8'h00, d);
  endtask

  task automatic host_read(input logic [7:0] e, input string req);
    push(1, e, req);
    cyc_drive(0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_pend", {7'd0, host_pend}, 8'h00);
    chk("R1 cpu_pend", {7'd0, cpu_pend}, 8'h00);
    chk("R1 cpu_rdata", cpu_rdata, 8'h00);
    chk("R1 host_rdata", host_rdata, 8'h00);

    // R3 outbound write, R2/R4 read with low address bits set
    cpu_write(8'h07, 8'hA5);
    chk("R3 host_pend set", {7'd0, host_pend}, 8'h01);
    cpu_read(8'h1F, 8'hA5, "R4_R2");
    chk("R4 host_pend kept", {7'd0, host_pend}, 8'h01);

    // R3 writes to other groups dropped
    cpu_write(8'h60, 8'h11);
    cpu_write(8'hE3, 8'h22);
    cpu_write(8'h20, 8'h33);
    cpu_read(8'h00, 8'hA5, "R3 ignored group write");
    chk("R3 cpu_pend untouched", {7'd0, cpu_pend}, 8'h00);

    // R6 status
    cpu_read(8'h40, 8'h01, "R6 status host only");

    // R9 host read
    host_read(8'hA5, "R9");
    chk("R9 host_pend cleared", {7'd0, host_pend}, 8'h00);

    // R8 host write, R6 status with low bits
    host_write(8'h3C);
    chk("R8 cpu_pend set", {7'd0, cpu_pend}, 8'h01);
    cpu_read(8'h5F, 8'h80, "R6_R2 status cpu only");

    // R5 inbound read
    cpu_read(8'h2A, 8'h3C, "R5");
    chk("R5 cpu_pend cleared", {7'd0, cpu_pend}, 8'h00);

    // R7 empty groups
    cpu_read(8'h60, 8'h00, "R7 g3");
    cpu_read(8'h9C, 8'h00, "R7 g4");
    cpu_read(8'hFF, 8'h00, "R7 g7");

    // R10 set wins on the inbound flag
    host_write(8'h77);
    push(0, 8'h77, "R10 old inbound byte");
    cyc_drive(0, 1, 1, 0, 8'h20, 8'h00, 8'h88);
    chk("R10 cpu_pend stays set", {7'd0, cpu_pend}, 8'h01);
    cpu_read(8'h20, 8'h88, "R10 new inbound byte");
    chk("R10 cpu_pend cleared", {7'd0, cpu_pend}, 8'h00);

    // R10 set wins on the outbound flag
    cpu_write(8'h00, 8'h5A);
    push(1, 8'h5A, "R10 old outbound byte");
    cyc_drive(1, 0, 0, 1, 8'h00, 8'hC3, 8'h00);
    chk("R10 host_pend stays set", {7'd0, host_pend}, 8'h01);
    host_read(8'hC3, "R10 new outbound byte");

    // R11 held read strobe acts once; host refills during the hold
    push(0, 8'h88, "R11 held read data");
    cpu_addr = 8'h20; cpu_rd = 1;
    @(negedge clk);
    host_wdata = 8'h42; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    @(negedge clk);
    cpu_rd = 0;
    @(negedge clk);
    chk("R11 cpu_pend not re-cleared", {7'd0, cpu_pend}, 8'h01);
    chk("R12 cpu_rdata held", cpu_rdata, 8'h88);

    // R12 hold across non-read activity
    cpu_write(8'h00, 8'h99);
    host_write(8'h10);
    chk("R12 cpu_rdata still held", cpu_rdata, 8'h88);
    chk("R12 host_rdata still held", host_rdata, 8'hC3);
    cpu_read(8'h20, 8'h10, "R12_R5 latest inbound");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R12 %0d expected reads never compared actual=%0d expected=0",
               exp_q.size(), exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule